// File: doc/BRIEF.md
# PCM Serial Frame Port

This block is the serial side of one voice-band PCM channel. It runs on the bit clock and is framed by an 8 kHz sync input. In each frame it shifts one transmit sample out on `pcm_out` and collects one receive sample from `pcm_in`. It does no companding, filtering or conversion. Samples arrive and leave as parallel words, and the receive word is marked by a one-cycle strobe.

Two sync timings are supported. In the long timing the first bit goes out on the edge where sync is first seen high. In the short timing sync is a pulse one clock wide, and the first bit goes out one clock later. The word is either an 8-bit companded code or a 14-bit two's-complement linear sample, and in both cases the most significant bit goes first. The frame type, word format and transmit idling can be changed between frames. The word format is captured when a frame starts.

Outside the data slot the serial output is held low. While the port is powered down the output is held high. When transmit is muted the port sends a fixed idle code in place of the sample.

Top module: `pcm_frame_port`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `pcm_out`, `rx_valid`, `frame_err` and `rx_word` are all zero.
- R2: With `short_frame`=0, a frame starts on the clock edge where `sync_in` is first sampled high after being low. The MSB appears on `pcm_out` after that edge, and each later edge presents the next lower bit.
- R3: With `short_frame`=1, a frame starts on the edge after the one where the `sync_in` pulse was sampled high. Bits then follow MSB first, one per edge.
- R4: With `linear_mode`=1 the word is 14 bits, taken from `tx_word[13:0]`, and `alaw_mode` has no effect. With `linear_mode`=0 the word is 8 bits, taken from `tx_word[7:0]`.
- R5: While not powered down, `pcm_out` is low on every cycle that does not carry a word bit. This includes the two bit positions that follow a 14-bit word.
- R6: The edge that samples `pwr_down` high drives `pcm_out` high, suppresses `rx_valid` and abandons any frame in progress. After release, `pcm_out` is low until the next frame starts, and that start raises no error.
- R7: With `tx_quiet`=1 the transmitted word ignores `tx_word`. It is 8'hD5 when `alaw_mode`=1, 8'hFF when `alaw_mode`=0, and 14'h0000 in linear mode.
- R8: `pcm_in` is sampled on the falling clock edge during each of the word's bit periods, MSB first. On the rising edge after the LSB was sampled, `rx_word` is updated and `rx_valid` is high for that one cycle. `rx_word` is right-justified, with bits 13:8 zero in 8-bit mode.
- R9: A frame start that arrives before the current word's last bit restarts framing with the new word. The aborted word gives no `rx_valid`. `frame_err` goes high at that start and stays high until the next frame start that arrives on time.
- R10: `linear_mode`, `alaw_mode` and `tx_quiet` are captured at frame start. Changing them during a frame has no effect until the next frame.
- R11: `rx_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state is in this domain |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | 8 kHz frame sync, synchronous to `bclk` |
| pcm_in | input | 1 | Serial receive data |
| short_frame | input | 1 | 0 = long sync timing, 1 = short sync pulse |
| linear_mode | input | 1 | 1 = 14-bit linear word, 0 = 8-bit companded |
| alaw_mode | input | 1 | Companding law for the idle code: 1 = A-law, 0 = µ-law |
| tx_quiet | input | 1 | 1 = send the idle code instead of the sample |
| pwr_down | input | 1 | 1 = powered down, output held high |
| tx_word | input | 14 | Parallel transmit sample, captured at frame start |
| pcm_out | output | 1 | Serial transmit data |
| rx_word | output | 14 | Last complete receive sample, right-justified |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` |
| frame_err | output | 1 | High from an early frame start until the next clean start |

## Verification
The hardest state to reach from the ports is a frame start that lands mid-word, while the previous word is still shifting. The bench brings it about by opening a frame, letting a few bits go out, and then raising sync again. It then checks that the new word goes out from its MSB, that no strobe appears for the cut-off word, and that the error flag clears at the following clean frame. Power-down is applied in the same mid-word state, so the bench can confirm that the abandoned frame leaves no error behind. Format bits are also toggled partway through a frame, so the bench can confirm they act only at the next start.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;

    localparam int PCM_LIN_W = 14;
    localparam int PCM_CMP_W = 8;

    localparam logic [PCM_CMP_W-1:0] IDLE_ALAW = 8'hD5;
    localparam logic [PCM_CMP_W-1:0] IDLE_ULAW = 8'hFF;

    typedef enum logic {
        SYNC_LONG  = 1'b0,
        SYNC_SHORT = 1'b1
    } sync_kind_e;

    typedef struct packed {
        logic linear;
        logic alaw;
        logic quiet;
    } word_fmt_t;

    function automatic logic [PCM_CMP_W-1:0] idle_code(input logic alaw);
        return alaw ? IDLE_ALAW : IDLE_ULAW;
    endfunction

endpackage

// File: rtl/pcm_sync_edge.sv
`timescale 1ns/1ps
module pcm_sync_edge
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_down,
    input  logic       sync_i,
    input  sync_kind_e kind,
    output logic       start
);
    logic sync_d1;
    logic sync_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d1 <= 1'b0;
            sync_d2 <= 1'b0;
        end else begin
            sync_d1 <= sync_i;
            sync_d2 <= sync_d1;
        end
    end

    // Long timing starts on the sampled rise; short timing one clock later.
    always_comb begin
        if (pwr_down)
            start = 1'b0;
        else if (kind == SYNC_SHORT)
            start = sync_d1 & ~sync_d2;
        else
            start = sync_i & ~sync_d1;
    end
endmodule

// File: rtl/pcm_slot_ctrl.sv
`timescale 1ns/1ps
module pcm_slot_ctrl #(
    parameter int LIN_W = pcm_port_pkg::PCM_LIN_W,
    parameter int CMP_W = pcm_port_pkg::PCM_CMP_W
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    input  logic start,
    input  logic linear_i,
    output logic slot_act,
    output logic last_bit,
    output logic lin_q,
    output logic frame_err
);
    localparam int IDX_W = $clog2(LIN_W);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = lin_q ? IDX_W'(LIN_W - 1) : IDX_W'(CMP_W - 1);
    assign last_bit = slot_act && (idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            slot_act  <= 1'b0;
            idx       <= '0;
            lin_q     <= 1'b0;
            frame_err <= 1'b0;
        end else if (start) begin
            slot_act  <= 1'b1;
            idx       <= '0;
            lin_q     <= linear_i;
            frame_err <= slot_act && !last_bit;
        end else if (slot_act) begin
            if (last_bit)
                slot_act <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/pcm_tx_shift.sv
`timescale 1ns/1ps
module pcm_tx_shift
    import pcm_port_pkg::*;
#(
    parameter int LIN_W = PCM_LIN_W,
    parameter int CMP_W = PCM_CMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_down,
    input  logic             start,
    input  logic             slot_act,
    input  logic             last_bit,
    input  word_fmt_t        fmt,
    input  logic [LIN_W-1:0] tx_word,
    output logic             pcm_out
);
    localparam int PAD_W = LIN_W - CMP_W;

    logic [LIN_W-1:0] sh;
    logic [LIN_W-1:0] load_word;
    logic [CMP_W-1:0] cmp_code;
    logic             pd_q;

    always_comb begin
        cmp_code = fmt.quiet ? CMP_W'(idle_code(fmt.alaw)) : tx_word[CMP_W-1:0];
        if (fmt.linear)
            load_word = fmt.quiet ? '0 : tx_word;
        else
            load_word = {cmp_code, {PAD_W{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            pd_q <= 1'b0;
        end else begin
            pd_q <= pwr_down;
            if (pwr_down)
                sh <= '0;
            else if (start)
                sh <= load_word;
            else if (slot_act && !last_bit)
                sh <= {sh[LIN_W-2:0], 1'b0};
        end
    end

    assign pcm_out = pd_q | (slot_act & sh[LIN_W-1]);
endmodule

// File: rtl/pcm_rx_shift.sv
`timescale 1ns/1ps
module pcm_rx_shift #(
    parameter int LIN_W = pcm_port_pkg::PCM_LIN_W,
    parameter int CMP_W = pcm_port_pkg::PCM_CMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_down,
    input  logic             slot_act,
    input  logic             last_bit,
    input  logic             lin_q,
    input  logic             pcm_in,
    output logic [LIN_W-1:0] rx_word,
    output logic             rx_valid
);
    localparam int PAD_W = LIN_W - CMP_W;

    logic [LIN_W-1:0] sh_n;
    logic             done;

    // Receive bits are taken mid-period, on the falling edge.
    always_ff @(negedge clk) begin
        if (rst)
            sh_n <= '0;
        else if (slot_act)
            sh_n <= {sh_n[LIN_W-2:0], pcm_in};
    end

    assign done = last_bit && !pwr_down;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= done;
            if (done)
                rx_word <= lin_q ? sh_n : {{PAD_W{1'b0}}, sh_n[CMP_W-1:0]};
        end
    end
endmodule

// File: rtl/pcm_frame_port.sv
`timescale 1ns/1ps
module pcm_frame_port
    import pcm_port_pkg::*;
#(
    parameter int LIN_W = PCM_LIN_W,
    parameter int CMP_W = PCM_CMP_W
) (
    input  logic             bclk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic             pcm_in,
    input  logic             short_frame,
    input  logic             linear_mode,
    input  logic             alaw_mode,
    input  logic             tx_quiet,
    input  logic             pwr_down,
    input  logic [LIN_W-1:0] tx_word,
    output logic             pcm_out,
    output logic [LIN_W-1:0] rx_word,
    output logic             rx_valid,
    output logic             frame_err
);
    logic       frame_start;
    logic       slot_act;
    logic       last_bit;
    logic       lin_q;
    word_fmt_t  fmt;

    assign fmt = '{linear: linear_mode, alaw: alaw_mode, quiet: tx_quiet};

    pcm_sync_edge u_sync (
        .clk      (bclk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .sync_i   (sync_in),
        .kind     (sync_kind_e'(short_frame)),
        .start    (frame_start)
    );

    pcm_slot_ctrl #(.LIN_W(LIN_W), .CMP_W(CMP_W)) u_slot (
        .clk       (bclk),
        .rst       (rst),
        .pwr_down  (pwr_down),
        .start     (frame_start),
        .linear_i  (linear_mode),
        .slot_act  (slot_act),
        .last_bit  (last_bit),
        .lin_q     (lin_q),
        .frame_err (frame_err)
    );

    pcm_tx_shift #(.LIN_W(LIN_W), .CMP_W(CMP_W)) u_tx (
        .clk      (bclk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .start    (frame_start),
        .slot_act (slot_act),
        .last_bit (last_bit),
        .fmt      (fmt),
        .tx_word  (tx_word),
        .pcm_out  (pcm_out)
    );

    pcm_rx_shift #(.LIN_W(LIN_W), .CMP_W(CMP_W)) u_rx (
        .clk      (bclk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .slot_act (slot_act),
        .last_bit (last_bit),
        .lin_q    (lin_q),
        .pcm_in   (pcm_in),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );
endmodule

// File: rtl/pcm_frame_port_chk.sv
`timescale 1ns/1ps
module pcm_frame_port_chk (
    input logic bclk,
    input logic rst,
    input logic pwr_down,
    input logic pcm_out,
    input logic rx_valid,
    input logic frame_err,
    input logic frame_start,
    input logic slot_act
);
    a_r6_pd_drives_high: assert property (@(posedge bclk) disable iff (rst)
        pwr_down |=> pcm_out);

    a_r6_pd_no_strobe: assert property (@(posedge bclk) disable iff (rst)
        pwr_down |=> !rx_valid);

    a_r11_strobe_single: assert property (@(posedge bclk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r8_strobe_after_slot: assert property (@(posedge bclk) disable iff (rst)
        rx_valid |-> $past(slot_act));

    a_r9_err_only_at_start: assert property (@(posedge bclk) disable iff (rst)
        $rose(frame_err) |-> $past(frame_start));

    a_r5_low_outside_slot: assert property (@(posedge bclk) disable iff (rst)
        (!slot_act && !frame_start && !pwr_down) |=> !pcm_out);
endmodule

bind pcm_frame_port pcm_frame_port_chk u_chk (
    .bclk        (bclk),
    .rst         (rst),
    .pwr_down    (pwr_down),
    .pcm_out     (pcm_out),
    .rx_valid    (rx_valid),
    .frame_err   (frame_err),
    .frame_start (frame_start),
    .slot_act    (slot_act)
);

// File: tb/test_pcm_frame_port.sv
`timescale 1ns/1ps
module test_pcm_frame_port;
    logic        bclk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_in = 1'b0;
    logic        pcm_in = 1'b0;
    logic        short_frame = 1'b0;
    logic        linear_mode = 1'b0;
    logic        alaw_mode = 1'b0;
    logic        tx_quiet = 1'b0;
    logic        pwr_down = 1'b0;
    logic [13:0] tx_word = '0;
    logic        pcm_out;
    logic [13:0] rx_word;
    logic        rx_valid;
    logic        frame_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 bclk = ~bclk;

    pcm_frame_port i_pcm_frame_port (
        .bclk        (bclk),
        .rst         (rst),
        .sync_in     (sync_in),
        .pcm_in      (pcm_in),
        .short_frame (short_frame),
        .linear_mode (linear_mode),
        .alaw_mode   (alaw_mode),
        .tx_quiet    (tx_quiet),
        .pwr_down    (pwr_down),
        .tx_word     (tx_word),
        .pcm_out     (pcm_out),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid),
        .frame_err   (frame_err)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    // Word expected on the line, right-justified (R4, R7).
    function automatic logic [13:0] exp_tx(input bit lin, input bit al,
                                           input bit q, input logic [13:0] w);
        if (lin) return q ? 14'h0000 : w;
        return {6'b0, q ? (al ? 8'hD5 : 8'hFF) : w[7:0]};
    endfunction

    // One frame; E0 is the first edge after this task drives sync high.
    task automatic frame(input bit sh, input bit lin, input bit al, input bit q,
                         input logic [13:0] txw, input logic [13:0] rxw,
                         input int per, input int hi, input bit exp_err, input bit flip);
        int len;
        int off;
        logic [13:0] tw;
        logic [13:0] rexp;
        string rq;
        len  = lin ? 14 : 8;
        off  = sh ? 1 : 0;
        tw   = exp_tx(lin, al, q, txw);
        rexp = lin ? rxw : {6'b0, rxw[7:0]};
        rq   = q ? "R7" : flip ? "R10" : lin ? "R4" : sh ? "R3" : "R2";
        short_frame = sh; linear_mode = lin; alaw_mode = al; tx_quiet = q;
        tx_word = txw; sync_in = 1'b1; pcm_in = 1'b0;
        for (int k = 0; k < per; k++) begin
            int idx;
            @(posedge bclk); #2;
            idx = k - off;
            sync_in = !sh && (k + 1 < hi);
            pcm_in  = (idx >= 0 && idx < len) ? rxw[len-1-idx] : 1'b0;
            if (flip && k == 2) begin
                linear_mode = !lin;
                alaw_mode   = !al;
                tx_quiet    = !q;
            end
            #5;
            if (idx >= 0 && idx < len)
                chk(rq, "data bit", pcm_out, tw[len-1-idx]);
            else
                chk("R5", "outside slot", pcm_out, 1'b0);
            chk("R8", "rx_valid", rx_valid, idx == len);
            if (idx == len)
                chk("R8", "rx_word", rx_word, rexp);
            if (k == off)
                chk("R9", "frame_err", frame_err, exp_err);
        end
    endtask

    // Opens a frame and leaves it after n cycles, mid-word.
    task automatic partial(input bit sh, input bit lin, input int n);
        short_frame = sh; linear_mode = lin; tx_quiet = 1'b0;
        tx_word = 14'($urandom); sync_in = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(posedge bclk); #2;
            sync_in = 1'b0;
            pcm_in  = 1'($urandom);
            #5;
            chk("R9", "no strobe mid-word", rx_valid, 1'b0);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL R0 watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240613));
        repeat (4) @(posedge bclk);
        #2 rst = 1'b0;
        #5;
        chk("R1", "pcm_out", pcm_out, 1'b0);
        chk("R1", "rx_valid", rx_valid, 1'b0);
        chk("R1", "frame_err", frame_err, 1'b0);
        chk("R1", "rx_word", rx_word, 14'h0);

        // Directed formats and sync timings.
        frame(0, 0, 0, 0, 14'h00A5, 14'h003C, 12, 1, 0, 0);
        frame(0, 0, 1, 1, 14'h1234, 14'h00C3, 12, 3, 0, 0);   // R7 A-law idle
        frame(0, 0, 0, 1, 14'h0000, 14'h0081, 12, 8, 0, 0);   // R7 mu-law idle
        frame(0, 1, 1, 1, 14'h3FFF, 14'h2AAA, 18, 14, 0, 0);  // R7 linear idle
        frame(0, 1, 1, 0, 14'h2C35, 14'h1555, 17, 5, 0, 0);   // R4 law ignored
        frame(1, 0, 0, 0, 14'h005A, 14'h00F0, 13, 1, 0, 0);   // R3
        frame(1, 1, 0, 0, 14'h3001, 14'h2003, 19, 1, 0, 0);   // R3 linear
        frame(0, 0, 0, 0, 14'h0096, 14'h0069, 14, 2, 0, 1);   // R10 to linear
        frame(1, 1, 0, 0, 14'h1F0E, 14'h0E1F, 19, 1, 0, 1);   // R10 to companded

        // R9: early sync restarts the word and flags one frame.
        partial(0, 0, 3);
        frame(0, 0, 0, 0, 14'h00B4, 14'h004B, 12, 1, 1, 0);
        frame(0, 0, 0, 0, 14'h0011, 14'h0022, 12, 1, 0, 0);
        partial(1, 1, 6);
        frame(1, 1, 0, 0, 14'h2BCD, 14'h1234, 18, 1, 1, 0);
        frame(1, 1, 0, 0, 14'h0F0F, 14'h30F0, 18, 1, 0, 0);

        // R6: power-down mid-word, output high, then abandoned frame.
        partial(0, 1, 4);
        @(posedge bclk); #2;
        pwr_down = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(posedge bclk); #2;
            sync_in = (k % 5 == 0);
            #5;
            chk("R6", "pcm_out high", pcm_out, 1'b1);
            chk("R6", "no strobe", rx_valid, 1'b0);
        end
        @(posedge bclk); #2;
        pwr_down = 1'b0;
        sync_in  = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge bclk); #7;
            chk("R6", "low after release", pcm_out, 1'b0);
            chk("R6", "no strobe after release", rx_valid, 1'b0);
        end
        frame(0, 1, 0, 0, 14'h1ABC, 14'h2DEF, 18, 2, 0, 0);

        // Random frames.
        for (int n = 0; n < 200; n++) begin
            bit sh;
            bit lin;
            bit al;
            bit q;
            bit fl;
            int len;
            sh  = 1'($urandom);
            lin = 1'($urandom);
            al  = 1'($urandom);
            q   = ($urandom % 4) == 0;
            fl  = ($urandom % 8) == 0;
            len = lin ? 14 : 8;
            frame(sh, lin, al, q, 14'($urandom), 14'($urandom),
                  len + 3 + int'($urandom % 6), 1 + int'($urandom % len), 0, fl);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule